// File: doc/BRIEF.md
# Indexed Block-Access Register Slave

This block is a two-wire serial bus slave that holds a small bank of 8-bit configuration registers. A host reaches them with indexed block transfers. Every write names a starting register and a byte count, then streams data bytes into successive registers. Every read first points the slave at a starting register with a short write phase. The host then issues a repeated start and reads. The slave answers with a count byte and then the register contents in increasing index order. The count byte is held in a register that the host can write, so software decides how long a read is meant to be.

The bus lines arrive asynchronously and are synchronized and edge-detected on the much faster system clock. SDA is driven through an open-drain enable: a high level on `sda_oe` pulls the line low. All register contents are exposed at once on a flat parallel vector so that surrounding logic can use them directly.

Top module: `smb_idx_slave`

## Requirements
- R1: The slave acknowledges (holds SDA low during the ninth clock) the address byte 0xD0 for writes and 0xD1 for reads, i.e. 7-bit address 0x68 with direction bit 0 or 1.
- R2: Any other address byte is not acknowledged. Until the next start or stop the slave then never drives SDA and changes no register.
- R3: A write transfer carries a starting index N, a byte count X and data bytes. The slave acknowledges all of them and stores the data in registers N, N+1, ... in order. Register k appears on `regs_o[8k+7:8k]`.
- R4: Data bytes beyond the count X of a write are not acknowledged and are discarded.
- R5: A data byte addressed to an index of 16 or above is acknowledged but discarded.
- R6: After acknowledging 0xD1, the slave sends the contents of register 8 as a count byte and then registers N, N+1, ..., most significant bit first.
- R7: A read of an index of 16 or above returns 0xFF.
- R8: After the host answers a read byte with a NACK, the slave releases SDA and stays silent until a stop or a repeated start.
- R9: After reset, register 8 holds 8 and every other register holds 0x00.
- R10: The slave changes SDA only while SCL is low. A falling SDA with SCL high is a start and a rising SDA with SCL high is a stop. Either one ends the transfer in progress, and a partly received byte is never stored.
- R11: A value written to register 8 is the count byte returned by later reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| regs_o | output | 128 | All registers, register k at bits 8k+7:8k |

## Verification
The hardest situation to reach is a transfer cut off mid-byte. A start or stop lands after only some data bits have been shifted, and the slave must drop the fragment and resynchronize. The bench builds its bus traffic from single-bit tasks. This lets it stop a byte after a few bits and issue a stop or repeated start, then prove through `regs_o` and a later full read that nothing partial was stored. Random block writes and reads with indices that straddle the end of the bank, plus writes that send more bytes than their count, exercise the out-of-range and beyond-count paths against a bench-side register model.

// File: rtl/smb_pkg.sv
package smb_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_INDEX,
        ST_COUNT,
        ST_WDATA,
        ST_RCOUNT,
        ST_RDATA,
        ST_WAIT
    } bus_state_e;

    // Synchronized line levels and single-cycle events on the system clock
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic byte_t reg_reset_value(input int idx, input int cnt_idx, input byte_t cnt_init);
        return (idx == cnt_idx) ? cnt_init : 8'h00;
    endfunction

    function automatic logic addr_hit(input byte_t b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

    function automatic logic is_rx(input bus_state_e s);
        return (s == ST_ADDR) || (s == ST_INDEX) || (s == ST_COUNT) || (s == ST_WDATA);
    endfunction

    function automatic logic is_tx(input bus_state_e s);
        return (s == ST_RCOUNT) || (s == ST_RDATA);
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

    // A start or stop can only be reported while SCL stays high
    AST_EVT_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) |-> $past(scl_pipe[STAGES-1])) else $error("event with SCL low"); // R10
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_pkg::*;
#(
    parameter int    NREG     = 16,
    parameter int    CNT_IDX  = 8,
    parameter byte_t CNT_INIT = 8'd8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  byte_t             waddr,
    input  byte_t             wdata,
    input  byte_t             raddr,
    output byte_t             rdata,
    output byte_t             cnt_o,
    output logic [NREG*8-1:0] flat_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = $clog2(NREG);

    byte_t mem [NREG];
    logic  w_in_range;
    logic  r_in_range;

    assign w_in_range = (32'(waddr) < NREG);
    assign r_in_range = (32'(raddr) < NREG);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= reg_reset_value(i, CNT_IDX, CNT_INIT);
            end
        end else if (we && w_in_range) begin
            mem[waddr[AW-1:0]] <= wdata;
        end
    end

    assign rdata = r_in_range ? mem[raddr[AW-1:0]] : 8'hFF;
    assign cnt_o = mem[CNT_IDX];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign flat_o[g*8 +: 8] = mem[g];
    end

    AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (we && !w_in_range) |=> $stable(flat_o)) else $error("out-of-range write changed bank"); // R5
    AST_OOR_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        !r_in_range |-> (rdata == 8'hFF)) else $error("out-of-range read not 0xFF"); // R7
endmodule

// File: rtl/smb_idx_slave.sv
module smb_idx_slave
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         NREG        = 16,
    parameter int         CNT_IDX     = 8,
    parameter int         CNT_INIT    = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] regs_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [3:0] BITS = 4'd8;

    line_ev_t   ev;
    bus_state_e state;
    bus_state_e after_st;
    bus_state_e rx_next;
    logic [3:0] bitcnt;
    logic       ack_phase;
    logic       host_ack;
    logic       rx_ack;
    logic       active;
    logic       rx_done;
    logic       we;
    byte_t      shreg;
    byte_t      txreg;
    byte_t      ptr;
    byte_t      wleft;
    byte_t      rdata;
    byte_t      cnt;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smb_regbank #(
        .NREG     (NREG),
        .CNT_IDX  (CNT_IDX),
        .CNT_INIT (byte_t'(CNT_INIT))
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (we),
        .waddr  (ptr),
        .wdata  (shreg),
        .raddr  (ptr),
        .rdata  (rdata),
        .cnt_o  (cnt),
        .flat_o (regs_o)
    );

    assign active  = (state != ST_IDLE) && (state != ST_WAIT);
    assign rx_done = active && ev.scl_fall && !ack_phase && (bitcnt == BITS) && is_rx(state);
    assign we      = rx_done && (state == ST_WDATA) && (wleft != 8'd0);

    // Decision on a fully received byte
    always_comb begin
        rx_ack  = 1'b1;
        rx_next = state;
        case (state)
            ST_ADDR: begin
                if (addr_hit(shreg, DEV_ADDR)) begin
                    rx_next = shreg[0] ? ST_RCOUNT : ST_INDEX;
                end else begin
                    rx_ack  = 1'b0;
                    rx_next = ST_WAIT;
                end
            end
            ST_INDEX: rx_next = ST_COUNT;
            ST_COUNT: rx_next = ST_WDATA;
            ST_WDATA: rx_ack  = (wleft != 8'd0);
            default:  rx_ack  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            after_st  <= ST_IDLE;
            bitcnt    <= '0;
            ack_phase <= 1'b0;
            host_ack  <= 1'b0;
            shreg     <= '0;
            txreg     <= '0;
            ptr       <= '0;
            wleft     <= '0;
            sda_oe    <= 1'b0;
        end else if (ev.start) begin
            state     <= ST_ADDR;
            bitcnt    <= '0;
            ack_phase <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (ev.stop) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            ack_phase <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (active) begin
            if (ev.scl_rise) begin
                if (ack_phase) begin
                    host_ack <= ~ev.sda;
                end else if (bitcnt != BITS) begin
                    shreg  <= {shreg[6:0], ev.sda};
                    bitcnt <= bitcnt + 4'd1;
                end
            end
            if (ev.scl_fall) begin
                if (ack_phase) begin
                    ack_phase <= 1'b0;
                    bitcnt    <= '0;
                    if (is_tx(state) && !host_ack) begin
                        state  <= ST_WAIT;
                        sda_oe <= 1'b0;
                    end else begin
                        state <= after_st;
                        if (after_st == ST_RCOUNT) begin
                            txreg  <= cnt;
                            sda_oe <= ~cnt[7];
                        end else if (after_st == ST_RDATA) begin
                            txreg  <= rdata;
                            sda_oe <= ~rdata[7];
                            ptr    <= ptr + 8'd1;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end else if (bitcnt == BITS) begin
                    ack_phase <= 1'b1;
                    if (is_rx(state)) begin
                        sda_oe   <= rx_ack;
                        after_st <= rx_next;
                        case (state)
                            ST_INDEX: ptr   <= shreg;
                            ST_COUNT: wleft <= shreg;
                            ST_WDATA: begin
                                if (wleft != 8'd0) begin
                                    ptr   <= ptr + 8'd1;
                                    wleft <= wleft - 8'd1;
                                end
                            end
                            default: ;
                        endcase
                    end else begin
                        sda_oe   <= 1'b0;
                        after_st <= ST_RDATA;
                    end
                end else if (is_tx(state)) begin
                    txreg  <= {txreg[6:0], 1'b0};
                    sda_oe <= ~txreg[6];
                end
            end
        end
    end

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!ev.scl || $past(ev.start || ev.stop))) else $error("SDA moved with SCL high"); // R10
    AST_START_ABORTS: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR && bitcnt == 4'd0 && !sda_oe)) else $error("start not honoured"); // R10
    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE && !sda_oe)) else $error("stop not honoured"); // R10
    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> !sda_oe) else $error("driving SDA while waiting"); // R8
    AST_NACK_BEYOND_COUNT: assert property (@(posedge clk) disable iff (rst)
        (rx_done && state == ST_WDATA && wleft == 8'd0) |=> !sda_oe) else $error("acked byte beyond count"); // R4
endmodule

// File: tb/tb_smb_idx_slave.sv
module tb_smb_idx_slave;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int Q    = 5;
    localparam int NREG = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [NREG*8-1:0] regs_o;

    int   vectors = 0;
    int   misses  = 0;
    bit   finished = 1'b0;
    logic [7:0] model [NREG];
    logic [7:0] buf_d [8];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smb_idx_slave dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_o (regs_o)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] model_flat();
        logic [127:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_restart();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic read_bit(output logic v);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        v = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        read_bit(v);
        ack = ~v;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic v;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            read_bit(v);
            b = {b[6:0], v};
        end
        send_bit(~give_ack);
    endtask

    // Block write of nsend bytes from buf_d with declared count cnt
    task automatic wr_block(input logic [7:0] idx, input int cnt, input int nsend);
        logic a;
        bus_start();
        send_byte(8'hD0, a); check("R1 write address ack", a, 1'b1);
        send_byte(idx, a);   check("R3 index ack", a, 1'b1);
        send_byte(8'(cnt), a); check("R3 count ack", a, 1'b1);
        for (int k = 0; k < nsend; k++) begin
            send_byte(buf_d[k], a);
            if (k < cnt) begin
                check("R3 data ack", a, 1'b1);
                if (int'(idx) + k < NREG) model[int'(idx) + k] = buf_d[k];
            end else begin
                check("R4 beyond-count nack", a, 1'b0);
            end
        end
        bus_stop();
        check("R3 R5 bank contents after write", regs_o, model_flat());
    endtask

    // Block read of nrd bytes from idx; optional silence probe after the NACK
    task automatic rd_block(input logic [7:0] idx, input int nrd, input bit probe);
        logic a;
        logic v;
        logic [7:0] b;
        logic [7:0] exp;
        bus_start();
        send_byte(8'hD0, a); check("R1 write address ack", a, 1'b1);
        send_byte(idx, a);   check("R6 index ack", a, 1'b1);
        bus_restart();
        send_byte(8'hD1, a); check("R1 read address ack", a, 1'b1);
        recv_byte(1'b1, b);  check("R6 R11 count byte", b, model[8]);
        for (int k = 0; k < nrd; k++) begin
            recv_byte(k < nrd - 1, b);
            if (int'(idx) + k < NREG) begin
                exp = model[int'(idx) + k];
                check("R6 read data", b, exp);
            end else begin
                check("R7 read beyond bank", b, 8'hFF);
            end
        end
        if (probe) begin
            for (int i = 0; i < 9; i++) begin
                read_bit(v);
                check("R8 silent after host NACK", v, 1'b1);
            end
        end
        bus_stop();
    endtask

    initial begin
        logic a;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NREG; i++) model[i] = (i == 8) ? 8'd8 : 8'h00;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 reset register values", regs_o, model_flat());
        check("R9 SDA released after reset", sda_oe, 1'b0);

        // Directed block write and read-back
        buf_d[0] = 8'hA5; buf_d[1] = 8'h3C; buf_d[2] = 8'h81;
        wr_block(8'd2, 3, 3);
        rd_block(8'd2, 3, 1'b0);

        // Foreign address: ignored until stop
        bus_start();
        send_byte(8'hD2, a); check("R2 foreign address nack", a, 1'b0);
        send_byte(8'h04, a); check("R2 no ack while ignoring", a, 1'b0);
        send_byte(8'h77, a); check("R2 no ack while ignoring", a, 1'b0);
        bus_stop();
        check("R2 bank unchanged", regs_o, model_flat());

        // More data than the declared count
        buf_d[0] = 8'h11; buf_d[1] = 8'h22;
        wr_block(8'd10, 1, 2);

        // Write straddling the end of the bank
        buf_d[0] = 8'hE1; buf_d[1] = 8'hE2; buf_d[2] = 8'hE3; buf_d[3] = 8'hE4;
        wr_block(8'd14, 4, 4);
        rd_block(8'd14, 4, 1'b0);

        // New count value
        buf_d[0] = 8'd3;
        wr_block(8'd8, 1, 1);
        rd_block(8'd0, 2, 1'b1);

        // Stop in the middle of a data byte
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'd5, a);
        send_byte(8'd1, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        check("R10 partial byte dropped on stop", regs_o, model_flat());

        // Repeated start in the middle of a data byte, then a clean write
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'd6, a);
        send_byte(8'd2, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_restart();
        send_byte(8'hD0, a); check("R10 restart accepted", a, 1'b1);
        send_byte(8'd6, a);
        send_byte(8'd1, a);
        send_byte(8'h5A, a); check("R10 data ack after restart", a, 1'b1);
        bus_stop();
        model[6] = 8'h5A;
        check("R10 bank after aborted byte", regs_o, model_flat());

        // Random block transfers
        for (int t = 0; t < 20; t++) begin
            if ($urandom % 2 == 0) begin
                int cnt;
                int extra;
                cnt   = int'($urandom % 4);
                extra = ($urandom % 4 == 0) ? 1 : 0;
                for (int k = 0; k < 8; k++) buf_d[k] = 8'($urandom);
                wr_block(8'($urandom % 19), cnt, cnt + extra);
            end else begin
                rd_block(8'($urandom % 19), 1 + int'($urandom % 4), 1'b0);
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule